// File: doc/BRIEF.md
# Serial Register Port with Shared Ready Output

This block is the serial slave front of a converter-style register file. A host lowers chip select, then clocks in one command byte. That byte names a target register and says whether the host is reading it or writing it. The data bits for that register follow: into the block on the serial data input, or out of it on the shared output pin. Every register has a fixed length, and that length sets how many data bits follow the command. Once they are done, the port waits for the next command byte without any change to chip select.

The shared output pin has two uses. While a read is shifting out, it carries the register bits. At every other moment while chip select is low, it shows an active-low ready flag, and a host can use the falling edge of that flag as an interrupt. A stand-in conversion core supplies a completion strobe together with a 24-bit result. The port drops the ready flag to high as soon as the strobe arrives, waits a fixed number of system clocks, and then latches the result and drives the flag low. Because of this, a result that nobody read never leaves the flag low across the next update. All serial inputs pass through synchronizers into the system clock domain.

Top module: `spi_reg_port`

## Requirements
- R1: While chip select (csN) is high, the output pin is released (sdoOe = 0, pin high-impedance). While csN is low, sdoOe = 1.
- R2: The port samples sdIn on rising serial clock edges, MSB first. A control register written with a 16-bit value reads back that same value.
- R3: Read data leaves the port MSB first. Each bit changes after a falling serial clock edge and holds until the next rising edge, so every bit is valid when that rising edge arrives.
- R4: The command byte uses bit 7 as a write-enable that must be 0. Bit 6 is 1 for a read and 0 for a write. Bits 5:0 hold the register address. A command byte with bit 7 = 1 is discarded, and the byte after it is taken as a command.
- R5: Register lengths depend on the address. Address 0 is the 8-bit status register. Addresses 1 to NUM_CTRL are the 16-bit control registers. Address NUM_CTRL+1 is the 24-bit data register. Every other address is 8 bits long and reads back as zero. In the status register, bit 7 holds the ready flag level and all other bits are 0.
- R6: While csN is low and no read is shifting out, the pin shows the ready flag. The flag goes low in the same cycle that a new result is latched into the data register.
- R7: A conversion strobe sends the ready flag high from the next system clock, even when the previous result was never read. The result is latched, and the flag goes low, LEAD_CLKS system clocks after the strobe.
- R8: Once all 24 bits of a data register read have been shifted out, the ready flag goes high and stays high until the next strobe.
- R9: If chip select rises in the middle of a transfer, the transfer is aborted and has no effect on any register. The next byte is then taken as a command.
- R10: Writes to the status register and the data register are framed to the register's length but change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdIn | input | 1 | Serial data into the port |
| sdoPin | output | 1 | Shared read-data / ready-flag pin, high-impedance while csN is high |
| sdoOe | output | 1 | Drive enable of sdoPin |
| convDone | input | 1 | One-cycle conversion-complete strobe |
| convResult | input | 24 | Conversion result that goes with convDone |

## Verification
The bench writes random 16-bit values to randomly chosen control registers and reads every control register back, which separates correct addressing from bit-order or off-by-one framing faults. Directed sequences drive a conversion strobe both after a read and over an unread result, and check the pin cycle by cycle, so an early latch, a late latch or a missing release of the flag shows up in a specific cycle. A second group of sequences sends a command byte with bit 7 set, aborts a transfer half-way, and writes to the read-only and unmapped addresses. The control register read that follows each of these shows whether framing survived and whether any register was changed.

// File: rtl/spi_reg_port_pkg.sv
package spi_reg_port_pkg;
  localparam int CMD_W  = 8;
  localparam int ADDR_W = 6;
  localparam int STAT_W = 8;
  localparam int CTRL_W = 16;
  localparam int DATA_W = 24;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {
    stCmd, stDec, stRead, stWrite, stCommit
  } xferState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              shiftIn;
    logic              loadOut;
    logic              shiftOut;
    logic              writeReg;
    logic              dataReadDone;
    logic [ADDR_W-1:0] addr;
  } dpStrobe_t;

  function automatic logic [CNT_W-1:0] regLen(input logic [ADDR_W-1:0] a, input int numCtrl);
    if (a == '0) return CNT_W'(STAT_W);
    else if (int'(a) <= numCtrl) return CNT_W'(CTRL_W);
    else if (int'(a) == numCtrl + 1) return CNT_W'(DATA_W);
    else return CNT_W'(STAT_W);
  endfunction
endpackage

// File: rtl/spi_reg_port_ctrl.sv
module spi_reg_port_ctrl
  import spi_reg_port_pkg::*;
#(
  parameter int NUM_CTRL = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             sdIn,
  input  logic [CMD_W-1:0] inByte,
  output logic             sdBit,
  output logic             readActive,
  output dpStrobe_t        stb
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(NUM_CTRL + 1);

  logic [2:0] sclkQ;
  logic [1:0] csQ;
  logic [1:0] sdQ;
  logic rise, fall, csOff;
  xferState_t state;
  logic [CNT_W-1:0] bitCnt, lenQ;
  logic [ADDR_W-1:0] addrQ;
  logic lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= '0;
      csQ   <= '1;
      sdQ   <= '0;
    end else begin
      sclkQ <= {sclkQ[1:0], sclk};
      csQ   <= {csQ[0], csN};
      sdQ   <= {sdQ[0], sdIn};
    end
  end

  assign rise    = sclkQ[1] & ~sclkQ[2];
  assign fall    = ~sclkQ[1] & sclkQ[2];
  assign csOff   = csQ[1];
  assign sdBit   = sdQ[1];
  assign lastBit = (bitCnt == lenQ - CNT_W'(1));
  assign readActive = (state == stRead);

  always_comb begin
    stb = '0;
    stb.addr = (state == stDec) ? inByte[ADDR_W-1:0] : addrQ;
    unique case (state)
      stCmd:    stb.shiftIn  = rise && !csOff;
      stDec:    stb.loadOut  = !csOff && !inByte[7] && inByte[6];
      stRead: begin
        stb.shiftOut     = fall && !csOff;
        stb.dataReadDone = rise && !csOff && lastBit && (addrQ == DATA_ADDR);
      end
      stWrite:  stb.shiftIn  = rise && !csOff;
      stCommit: stb.writeReg = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= stCmd;
      bitCnt <= '0;
      lenQ   <= CNT_W'(STAT_W);
      addrQ  <= '0;
    end else if (state == stCommit) begin
      state <= stCmd;
    end else if (csOff) begin
      state  <= stCmd;
      bitCnt <= '0;
    end else begin
      unique case (state)
        stCmd: if (rise) begin
          if (bitCnt == CNT_W'(CMD_W - 1)) begin
            state  <= stDec;
            bitCnt <= '0;
          end else bitCnt <= bitCnt + CNT_W'(1);
        end
        stDec: begin
          if (inByte[7]) state <= stCmd;
          else begin
            addrQ <= inByte[ADDR_W-1:0];
            lenQ  <= regLen(inByte[ADDR_W-1:0], NUM_CTRL);
            state <= inByte[6] ? stRead : stWrite;
          end
        end
        stRead, stWrite: if (rise) begin
          if (lastBit) begin
            state  <= (state == stWrite) ? stCommit : stCmd;
            bitCnt <= '0;
          end else bitCnt <= bitCnt + CNT_W'(1);
        end
        default: state <= stCmd;
      endcase
    end
  end

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    (csOff && state != stCommit) |=> (state == stCmd && bitCnt == '0));
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == stRead || state == stWrite) |-> (bitCnt < lenQ));
  assert_bad_cmd_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == stDec && inByte[7]) |=> (state == stCmd));
endmodule

// File: rtl/spi_reg_port_dp.sv
module spi_reg_port_dp
  import spi_reg_port_pkg::*;
#(
  parameter int NUM_CTRL  = 4,
  parameter int LEAD_CLKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdBit,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convResult,
  output logic [CMD_W-1:0]  inByte,
  output logic              outBit,
  output logic              rdyN
);
  localparam int LEAD_W = $clog2(LEAD_CLKS + 1);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(NUM_CTRL + 1);

  logic [DATA_W-1:0] shIn, outSh, dataReg, pendRes, readWord;
  logic [CTRL_W-1:0] ctrlRegs [NUM_CTRL];
  logic pending;
  logic [LEAD_W-1:0] leadCnt;

  assign inByte = shIn[CMD_W-1:0];

  always_comb begin
    readWord = '0;
    if (stb.addr == '0) readWord = {rdyN, {(DATA_W-1){1'b0}}};
    else if (stb.addr == DATA_ADDR) readWord = dataReg;
    else
      for (int i = 0; i < NUM_CTRL; i++)
        if (stb.addr == ADDR_W'(i + 1)) readWord = {ctrlRegs[i], {(DATA_W-CTRL_W){1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shIn   <= '0;
      outSh  <= '0;
      outBit <= 1'b0;
      for (int i = 0; i < NUM_CTRL; i++) ctrlRegs[i] <= '0;
    end else begin
      if (stb.shiftIn) shIn <= {shIn[DATA_W-2:0], sdBit};
      if (stb.loadOut) outSh <= readWord;
      else if (stb.shiftOut) begin
        outBit <= outSh[DATA_W-1];
        outSh  <= {outSh[DATA_W-2:0], 1'b0};
      end
      if (stb.writeReg)
        for (int i = 0; i < NUM_CTRL; i++)
          if (stb.addr == ADDR_W'(i + 1)) ctrlRegs[i] <= shIn[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdyN    <= 1'b1;
      pending <= 1'b0;
      pendRes <= '0;
      dataReg <= '0;
      leadCnt <= '0;
    end else if (convDone) begin
      rdyN    <= 1'b1;
      pending <= 1'b1;
      pendRes <= convResult;
      leadCnt <= LEAD_W'(LEAD_CLKS - 1);
    end else if (pending) begin
      if (leadCnt == '0) begin
        dataReg <= pendRes;
        rdyN    <= 1'b0;
        pending <= 1'b0;
      end else leadCnt <= leadCnt - LEAD_W'(1);
    end else if (stb.dataReadDone) begin
      rdyN <= 1'b1;
    end
  end

  assert_strobe_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> (rdyN && pending));
  assert_latch_with_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyN) |-> ($past(pending) && dataReg == $past(pendRes)));
  assert_read_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataReadDone && !pending && !convDone) |=> rdyN);
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_port_pkg::*;
#(
  parameter int NUM_CTRL  = 4,
  parameter int LEAD_CLKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdIn,
  output logic              sdoPin,
  output logic              sdoOe,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convResult
);
  dpStrobe_t stb;
  logic [CMD_W-1:0] inByte;
  logic sdBit, readActive, outBit, rdyN;

  spi_reg_port_ctrl #(.NUM_CTRL(NUM_CTRL)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdIn(sdIn),
    .inByte(inByte), .sdBit(sdBit), .readActive(readActive), .stb(stb)
  );

  spi_reg_port_dp #(.NUM_CTRL(NUM_CTRL), .LEAD_CLKS(LEAD_CLKS)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sdBit(sdBit),
    .convDone(convDone), .convResult(convResult),
    .inByte(inByte), .outBit(outBit), .rdyN(rdyN)
  );

  assign sdoOe  = ~csN;
  assign sdoPin = csN ? 1'bz : (readActive ? outBit : rdyN);
endmodule

// File: tb/spi_reg_port_tb_top.sv
module spi_reg_port_tb_top;
  localparam int NUM_CTRL = 4;
  localparam int LEAD = 4;
  localparam int HP = 8;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdIn = 1'b0;
  logic convDone = 1'b0;
  logic [23:0] convResult = '0;
  wire sdoPin;
  logic sdoOe;
  int checks = 0, errors = 0;
  logic [15:0] ctrlModel [NUM_CTRL];
  logic [23:0] dataModel = '0;
  logic rdyModel = 1'b1;

  always #2 clk = ~clk;

  spi_reg_port #(.NUM_CTRL(NUM_CTRL), .LEAD_CLKS(LEAD)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdIn(sdIn),
    .sdoPin(sdoPin), .sdoOe(sdoOe), .convDone(convDone), .convResult(convResult)
  );

  function automatic int modelLen(input logic [5:0] a);
    if (a == 0) return 8;
    if (int'(a) <= NUM_CTRL) return 16;
    if (int'(a) == NUM_CTRL + 1) return 24;
    return 8;
  endfunction

  function automatic logic [23:0] modelRead(input logic [5:0] a);
    if (a == 0) return {16'h0, rdyModel, 7'h0};
    if (int'(a) <= NUM_CTRL) return {8'h0, ctrlModel[int'(a) - 1]};
    if (int'(a) == NUM_CTRL + 1) return dataModel;
    return '0;
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csLow();
    @(negedge clk) csN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (HP) @(negedge clk);
    csN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic sendBits(input int n, input logic [23:0] val, output logic [23:0] rd);
    rd = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sdIn = val[i];
      repeat (HP) @(negedge clk);
      rd = {rd[22:0], sdoPin};
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic regRead(input logic [5:0] a, output logic [23:0] rd, output logic pinAfter);
    logic [23:0] dummy;
    csLow();
    sendBits(8, {16'h0, 2'b01, a}, dummy);
    sendBits(modelLen(a), 24'h0, rd);
    repeat (HP) @(negedge clk);
    pinAfter = sdoPin;
    csHigh();
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [23:0] v);
    logic [23:0] dummy;
    csLow();
    sendBits(8, {16'h0, 2'b00, a}, dummy);
    sendBits(modelLen(a), v, dummy);
    csHigh();
  endtask

  // strobe with cs low; pin checked each cycle against the lead window
  task automatic convPulse(input logic [23:0] v, input string req);
    @(negedge clk) begin convDone = 1'b1; convResult = v; end
    @(negedge clk) convDone = 1'b0;
    chk(req, {23'h0, sdoPin}, 24'h1);
    for (int k = 1; k < LEAD; k++) begin
      @(negedge clk);
      chk(req, {23'h0, sdoPin}, 24'h1);
    end
    @(negedge clk);
    chk("R6", {23'h0, sdoPin}, 24'h0);
    dataModel = v;
    rdyModel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] rd, dummy;
    logic pin;
    void'($urandom(32'd4711));
    for (int i = 0; i < NUM_CTRL; i++) ctrlModel[i] = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1", {23'h0, sdoOe}, 24'h0);
    regRead(6'd0, rd, pin);
    chk("R5", rd, modelRead(6'd0));

    // R2 R3: random control register traffic
    for (int it = 0; it < 16; it++) begin
      int a;
      logic [15:0] v;
      a = 1 + int'($urandom % NUM_CTRL);
      v = 16'($urandom);
      regWrite(6'(a), {8'h0, v});
      ctrlModel[a - 1] = v;
    end
    for (int a = 1; a <= NUM_CTRL; a++) begin
      regRead(6'(a), rd, pin);
      chk("R2_R3", rd, modelRead(6'(a)));
    end
    regWrite(6'd1, 24'h00FFFF); ctrlModel[0] = 16'hFFFF;
    regRead(6'd1, rd, pin); chk("R3", rd, modelRead(6'd1));
    regWrite(6'd1, 24'h008001); ctrlModel[0] = 16'h8001;
    regRead(6'd1, rd, pin); chk("R3", rd, modelRead(6'd1));

    // R6 R7: conversions with cs low
    csLow();
    chk("R1", {23'h0, sdoOe}, 24'h1);
    chk("R6", {23'h0, sdoPin}, 24'h1);
    convPulse(24'h5A3C96, "R7");
    convPulse(24'hA1B2C3, "R7");
    csHigh();
    regRead(6'd0, rd, pin);
    chk("R5", rd, modelRead(6'd0));
    chk("R6", {23'h0, pin}, 24'h0);

    // R8: full data read releases flag
    regRead(6'(NUM_CTRL + 1), rd, pin);
    chk("R5", rd, 24'hA1B2C3);
    chk("R8", {23'h0, pin}, 24'h1);
    rdyModel = 1'b1;
    csLow();
    repeat (30) @(negedge clk);
    chk("R8", {23'h0, sdoPin}, 24'h1);
    csHigh();
    regRead(6'(NUM_CTRL + 1), rd, pin);
    chk("R8", rd, 24'hA1B2C3);

    // R10: read-only targets
    regWrite(6'(NUM_CTRL + 1), 24'h123456);
    regWrite(6'd0, 24'h00007F);
    regRead(6'(NUM_CTRL + 1), rd, pin); chk("R10", rd, modelRead(6'(NUM_CTRL + 1)));
    regRead(6'd0, rd, pin); chk("R10", rd, modelRead(6'd0));
    regRead(6'd2, rd, pin); chk("R10", rd, modelRead(6'd2));

    // R4: bad command byte discarded, next byte is a command
    csLow();
    sendBits(8, 24'h0000C1, dummy);
    sendBits(8, {16'h0, 2'b01, 6'd1}, dummy);
    sendBits(16, 24'h0, rd);
    csHigh();
    chk("R4", rd, modelRead(6'd1));
    csLow();
    sendBits(8, 24'h000082, dummy);
    sendBits(8, {16'h0, 2'b00, 6'd3}, dummy);
    sendBits(16, 24'h00BEEF, dummy);
    csHigh();
    ctrlModel[2] = 16'hBEEF;
    regRead(6'd3, rd, pin); chk("R4", rd, modelRead(6'd3));

    // R9: aborts in data and in command phase
    csLow();
    sendBits(8, {16'h0, 2'b00, 6'd2}, dummy);
    sendBits(8, 24'h0000A5, dummy);
    csHigh();
    regRead(6'd2, rd, pin); chk("R9", rd, modelRead(6'd2));
    csLow();
    sendBits(4, 24'h00000F, dummy);
    csHigh();
    regRead(6'd4, rd, pin); chk("R9", rd, modelRead(6'd4));

    // R5: unmapped address
    regRead(6'd48, rd, pin); chk("R5", rd, 24'h0);
    regWrite(6'd48, 24'h0000FF);
    regRead(6'd1, rd, pin); chk("R5", rd, modelRead(6'd1));

    csHigh();
    chk("R1", {23'h0, sdoOe}, 24'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule